// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block keeps the two threshold offsets that a synchronous FIFO's almost-empty and almost-full comparators use. It controls how software or board logic loads and reads back those offsets. While master reset is held, both offsets take one of two default values, chosen by the level of the load-select pin. At the same time the block captures whether the offsets will be programmed through a serial bitstream or through the parallel data bus. That choice stays fixed until the next master reset.

With load-select LOW, the write and read strobes reach the offset registers instead of the FIFO memory. Writes and reads each keep their own pointer. Each pointer visits the almost-empty register first, then the almost-full register, and keeps alternating. With load-select HIGH, the same strobes become plain memory write and read requests for the FIFO core. Serial programming shifts one bit per write-clock edge through a 30-bit chain. The chain runs from the almost-empty LSB up to the almost-full MSB. The sequence is the same whichever output mode the FIFO uses.

The strobe interface has no back-pressure. Every strobe is accepted in the cycle it is sampled. Read-back data comes with a one-cycle valid flag, and that flag cannot be stalled.

Top module: `ofs_flag_loader`

## Requirements
- R1: On every write-clock edge with `mrst_n` LOW, both offsets are set to 0x03FF if `load_n` is HIGH and to 0x007F if `load_n` is LOW. Both access pointers return to the almost-empty register, and `rd_data` clears to 0.
- R2: `serial_sel` is captured on each write-clock edge while `mrst_n` is LOW (1 = serial method, 0 = parallel method). The captured method ignores `serial_sel` from then until the next master reset.
- R3: In parallel method, a cycle with `load_n`=0 and `wr_en_n`=0 writes `din[14:0]` into the register the write pointer selects. The pointer then alternates: almost-empty, almost-full, almost-empty, and so on.
- R4: In either method, a cycle with `load_n`=0 and `rd_en_n`=0 returns the selected offset on the next read-clock edge. It appears in `rd_data[14:0]` with bits 17:15 zero, and `rd_valid` is 1 for that cycle. The read pointer alternates in the same order as the write pointer.
- R5: In serial method, each write-clock edge with `ser_en_n`=0 shifts `ser_bit` into bit 14 of the almost-full offset. The almost-full LSB moves into almost-empty bit 14, and every other bit moves down one place. After 30 shifts, the first bit is almost-empty bit 0 and the last bit is almost-full bit 14.
- R6: A parallel register write in serial method leaves both offsets unchanged. A serial shift in parallel method also leaves both offsets unchanged.
- R7: A cycle that requests a parallel register write (`load_n`=0, `wr_en_n`=0) never shifts the serial chain, even with `ser_en_n`=0.
- R8: `mem_wr_req` = `load_n` HIGH and `wr_en_n` LOW, and `mem_rd_req` = `load_n` HIGH and `rd_en_n` LOW, both combinational. Both are 0 while `mrst_n` is LOW.
- R9: A cycle with no register read leaves `rd_valid` at 0 and `rd_data` unchanged. A cycle with all enables HIGH changes no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock: offsets, serial chain, write pointer |
| rd_clk | input | 1 | Read clock: read pointer and read-back register |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks |
| load_n | input | 1 | LOW selects offset-register access; level at reset picks defaults |
| serial_sel | input | 1 | Programming method sampled during reset (1 = serial) |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_en_n | input | 1 | Read strobe, active low |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_bit | input | 1 | Serial data bit |
| din | input | 18 | Parallel write data |
| empty_ofs | output | 15 | Almost-empty offset to the flag logic |
| full_ofs | output | 15 | Almost-full offset to the flag logic |
| rd_data | output | 18 | Offset read-back data |
| rd_valid | output | 1 | High for one cycle when rd_data was just loaded |
| mem_wr_req | output | 1 | Memory write request to the FIFO core |
| mem_rd_req | output | 1 | Memory read request to the FIFO core |

## Verification
The bench builds the block with its default parameters: 15-bit offsets, an 18-bit bus and the 0x007F/0x03FF defaults. With these values the full 30-bit serial chain is reachable, including the crossing from almost-empty bit 14 to almost-full bit 0 and the zero fill of bits 17:15 on read-back. Both clocks share one source, so each read-back lines up cycle for cycle with the write that came before it. Both reset defaults and both programming methods are each reached through their own master reset.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  // decoded strobe set for one cycle
  typedef struct packed {
    logic reg_wr;   // parallel offset write request
    logic reg_rd;   // parallel offset read request
    logic shift;    // serial shift request (already yields to reg_wr)
    logic mem_wr;   // FIFO memory write request
    logic mem_rd;   // FIFO memory read request
  } ofs_cmd_t;

  localparam int unsigned NUM_OFS = 2;  // index 0 = almost-empty, 1 = almost-full

endpackage

// File: rtl/ofs_cmd_decode.sv
module ofs_cmd_decode
  import ofs_pkg::*;
(
  input  logic     mrst_n,
  input  logic     load_n,
  input  logic     wr_en_n,
  input  logic     rd_en_n,
  input  logic     ser_en_n,
  output ofs_cmd_t cmd
);

  logic live;
  logic reg_sel;

  always_comb begin
    live        = mrst_n;
    reg_sel     = ~load_n;
    cmd.reg_wr  = live & reg_sel & ~wr_en_n;
    cmd.reg_rd  = live & reg_sel & ~rd_en_n;
    cmd.mem_wr  = live & ~reg_sel & ~wr_en_n;
    cmd.mem_rd  = live & ~reg_sel & ~rd_en_n;
    // a parallel write request always blocks the serial chain (R7)
    cmd.shift   = live & ~ser_en_n & ~cmd.reg_wr;
  end

endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
  import ofs_pkg::*;
#(
  parameter int unsigned   OFS_W  = 15,
  parameter logic [OFS_W-1:0] DEF_LO = 'h007F,
  parameter logic [OFS_W-1:0] DEF_HI = 'h03FF
) (
  input  logic                          clk,
  input  logic                          mrst_n,
  input  logic                          load_n,
  input  logic                          serial_sel,
  input  logic                          reg_wr,
  input  logic                          shift,
  input  logic [OFS_W-1:0]              wr_word,
  input  logic                          ser_bit,
  output logic [NUM_OFS-1:0][OFS_W-1:0] ofs,
  output prog_mode_e                    mode
);

  localparam int unsigned CHAIN_W = NUM_OFS * OFS_W;

  logic               wr_ptr;
  logic               par_wr_en;
  logic               ser_en;
  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] chain_nxt;

  assign chain     = ofs;
  assign chain_nxt = {ser_bit, chain[CHAIN_W-1:1]};
  assign par_wr_en = reg_wr & (mode == PROG_PARALLEL);
  assign ser_en    = shift  & (mode == PROG_SERIAL);

  // method latch: follows serial_sel only while master reset is held
  always_ff @(posedge clk) begin
    if (!mrst_n) mode <= prog_mode_e'(serial_sel);
  end

  always_ff @(posedge clk) begin
    if (!mrst_n)        wr_ptr <= 1'b0;
    else if (par_wr_en) wr_ptr <= ~wr_ptr;
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (!mrst_n)
        ofs[g] <= load_n ? DEF_HI : DEF_LO;
      else if (par_wr_en && (wr_ptr == g[0]))
        ofs[g] <= wr_word;
      else if (ser_en)
        ofs[g] <= chain_nxt[g*OFS_W +: OFS_W];
    end
  end

  // R1: defaults follow load_n during reset
  a_r1_reset_default: assert property (@(posedge clk)
    !mrst_n |=> (ofs[0] == ($past(load_n) ? DEF_HI : DEF_LO)) &&
                (ofs[1] == ($past(load_n) ? DEF_HI : DEF_LO)));

  // R2: method frozen outside reset
  a_r2_mode_held: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(mode));

  // R3: parallel write lands in the pointed register
  a_r3_wr_empty: assert property (@(posedge clk) disable iff (!mrst_n)
    (par_wr_en && !wr_ptr) |=> ofs[0] == $past(wr_word));
  a_r3_wr_full: assert property (@(posedge clk) disable iff (!mrst_n)
    (par_wr_en && wr_ptr) |=> ofs[1] == $past(wr_word));

  // R5: serial chain shifts toward the almost-empty LSB
  a_r5_shift: assert property (@(posedge clk) disable iff (!mrst_n)
    (shift && mode == PROG_SERIAL) |=>
      chain == {$past(ser_bit), $past(chain[CHAIN_W-1:1])});

  // R6 / R7: parallel write in serial method touches nothing
  a_r6_wr_ignored: assert property (@(posedge clk) disable iff (!mrst_n)
    (reg_wr && mode == PROG_SERIAL) |=> $stable(chain));

  // R6: shift in parallel method touches nothing
  a_r6_shift_ignored: assert property (@(posedge clk) disable iff (!mrst_n)
    (shift && mode == PROG_PARALLEL) |=> $stable(chain));

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W = 15,
  parameter int unsigned BUS_W = 18
) (
  input  logic                          clk,
  input  logic                          mrst_n,
  input  logic                          reg_rd,
  input  logic [NUM_OFS-1:0][OFS_W-1:0] ofs,
  output logic [BUS_W-1:0]              rd_data,
  output logic                          rd_valid
);

  localparam int unsigned PAD_W = BUS_W - OFS_W;

  logic rd_ptr;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      rd_ptr   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) begin
        rd_ptr  <= ~rd_ptr;
        rd_data <= {{PAD_W{1'b0}}, ofs[rd_ptr]};
      end
    end
  end

  // R4: read valid and value
  a_r4_valid: assert property (@(posedge clk) disable iff (!mrst_n)
    reg_rd |=> rd_valid);
  a_r4_empty_val: assert property (@(posedge clk) disable iff (!mrst_n)
    (reg_rd && !rd_ptr) |=> rd_data == {{PAD_W{1'b0}}, $past(ofs[0])});
  a_r4_full_val: assert property (@(posedge clk) disable iff (!mrst_n)
    (reg_rd && rd_ptr) |=> rd_data == {{PAD_W{1'b0}}, $past(ofs[1])});

  // R9: idle read side holds
  a_r9_idle: assert property (@(posedge clk) disable iff (!mrst_n)
    !reg_rd |=> !rd_valid && $stable(rd_data));

endmodule

// File: rtl/ofs_flag_loader.sv
module ofs_flag_loader
  import ofs_pkg::*;
#(
  parameter int unsigned      OFS_W  = 15,
  parameter int unsigned      BUS_W  = 18,
  parameter logic [OFS_W-1:0] DEF_LO = 'h007F,
  parameter logic [OFS_W-1:0] DEF_HI = 'h03FF
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             mrst_n,
  input  logic             load_n,
  input  logic             serial_sel,
  input  logic             wr_en_n,
  input  logic             rd_en_n,
  input  logic             ser_en_n,
  input  logic             ser_bit,
  input  logic [BUS_W-1:0] din,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             mem_wr_req,
  output logic             mem_rd_req
);

  ofs_cmd_t                    cmd;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs;
  prog_mode_e                  mode;

  ofs_cmd_decode i_decode (
    .mrst_n   (mrst_n),
    .load_n   (load_n),
    .wr_en_n  (wr_en_n),
    .rd_en_n  (rd_en_n),
    .ser_en_n (ser_en_n),
    .cmd      (cmd)
  );

  ofs_regfile #(
    .OFS_W  (OFS_W),
    .DEF_LO (DEF_LO),
    .DEF_HI (DEF_HI)
  ) i_regfile (
    .clk        (wr_clk),
    .mrst_n     (mrst_n),
    .load_n     (load_n),
    .serial_sel (serial_sel),
    .reg_wr     (cmd.reg_wr),
    .shift      (cmd.shift),
    .wr_word    (din[OFS_W-1:0]),
    .ser_bit    (ser_bit),
    .ofs        (ofs),
    .mode       (mode)
  );

  ofs_readback #(
    .OFS_W (OFS_W),
    .BUS_W (BUS_W)
  ) i_readback (
    .clk      (rd_clk),
    .mrst_n   (mrst_n),
    .reg_rd   (cmd.reg_rd),
    .ofs      (ofs),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign empty_ofs  = ofs[0];
  assign full_ofs   = ofs[1];
  assign mem_wr_req = cmd.mem_wr;
  assign mem_rd_req = cmd.mem_rd;

  // R8: no memory traffic under master reset
  a_r8_quiet_reset: assert property (@(posedge wr_clk)
    !mrst_n |-> !mem_wr_req && !mem_rd_req);

  // R8: register access and memory request are exclusive
  a_r8_exclusive: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !load_n |-> !mem_wr_req && !mem_rd_req);

endmodule

// File: tb/test_ofs_flag_loader.sv
module test_ofs_flag_loader;

  logic        clk = 1'b0;
  logic        mrst_n, load_n, serial_sel, wr_en_n, rd_en_n, ser_en_n, ser_bit;
  logic [17:0] din;
  logic [14:0] empty_ofs, full_ofs;
  logic [17:0] rd_data;
  logic        rd_valid, mem_wr_req, mem_rd_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  ofs_flag_loader i_ofs_flag_loader (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .load_n(load_n),
    .serial_sel(serial_sel), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .ser_en_n(ser_en_n), .ser_bit(ser_bit), .din(din),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data),
    .rd_valid(rd_valid), .mem_wr_req(mem_wr_req), .mem_rd_req(mem_rd_req)
  );

  typedef struct packed {
    logic ld, we, re, se;
    logic [17:0] d;
    logic [14:0] e, f;
    logic mw, mr;
    logic [17:0] rd;
    logic vld;
  } vec_t;

  // parallel method, defaults 0x007F
  localparam vec_t VEC [11] = '{
    '{1'b1,1'b1,1'b1,1'b1, 18'h00000, 15'h007F, 15'h007F, 1'b0,1'b0, 18'h00000, 1'b0}, // R9 nop
    '{1'b0,1'b0,1'b1,1'b1, 18'h01234, 15'h1234, 15'h007F, 1'b0,1'b0, 18'h00000, 1'b0}, // R3 empty
    '{1'b0,1'b0,1'b1,1'b1, 18'h25555, 15'h1234, 15'h5555, 1'b0,1'b0, 18'h00000, 1'b0}, // R3 full
    '{1'b0,1'b0,1'b1,1'b1, 18'h00042, 15'h0042, 15'h5555, 1'b0,1'b0, 18'h00000, 1'b0}, // R3 wrap
    '{1'b0,1'b1,1'b0,1'b1, 18'h00000, 15'h0042, 15'h5555, 1'b0,1'b0, 18'h00042, 1'b1}, // R4 empty
    '{1'b0,1'b1,1'b0,1'b1, 18'h00000, 15'h0042, 15'h5555, 1'b0,1'b0, 18'h05555, 1'b1}, // R4 full
    '{1'b1,1'b0,1'b1,1'b1, 18'h3FFFF, 15'h0042, 15'h5555, 1'b1,1'b0, 18'h05555, 1'b0}, // R8 mem wr
    '{1'b1,1'b1,1'b0,1'b1, 18'h00000, 15'h0042, 15'h5555, 1'b0,1'b1, 18'h05555, 1'b0}, // R8 mem rd
    '{1'b1,1'b1,1'b1,1'b0, 18'h00000, 15'h0042, 15'h5555, 1'b0,1'b0, 18'h05555, 1'b0}, // R6 shift ignored
    '{1'b0,1'b1,1'b1,1'b1, 18'h00000, 15'h0042, 15'h5555, 1'b0,1'b0, 18'h05555, 1'b0}, // R9 idle
    '{1'b0,1'b0,1'b0,1'b1, 18'h00777, 15'h0042, 15'h0777, 1'b0,1'b0, 18'h00042, 1'b1}  // R3/R4 together
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ld, we, re, se, sb, input logic [17:0] d);
    @(negedge clk);
    load_n = ld; wr_en_n = we; rd_en_n = re; ser_en_n = se; ser_bit = sb; din = d;
    #1;
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic ld, input logic ssel);
    @(negedge clk);
    mrst_n = 1'b0; load_n = ld; serial_sel = ssel;
    wr_en_n = 1'b1; rd_en_n = 1'b1; ser_en_n = 1'b1; ser_bit = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mrst_n = 1'b1; load_n = 1'b1;
    #1;
  endtask

  localparam logic [14:0] SE = 15'h1A2B;
  localparam logic [14:0] SF = 15'h6C3D;

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; load_n = 1'b1; serial_sel = 1'b0; wr_en_n = 1'b1;
    rd_en_n = 1'b1; ser_en_n = 1'b1; ser_bit = 1'b0; din = '0;

    // R8: requests held off during reset
    @(negedge clk);
    load_n = 1'b1; wr_en_n = 1'b0; rd_en_n = 1'b0;
    #1;
    chk("R8 reset mem_wr", mem_wr_req, 0);
    chk("R8 reset mem_rd", mem_rd_req, 0);

    // R1: low defaults, parallel method
    do_reset(1'b0, 1'b0);
    chk("R1 empty default lo", empty_ofs, 15'h007F);
    chk("R1 full default lo", full_ofs, 15'h007F);
    chk("R1 rd_data cleared", rd_data, 0);
    chk("R1 rd_valid low", rd_valid, 0);

    foreach (VEC[i]) begin
      drive(VEC[i].ld, VEC[i].we, VEC[i].re, VEC[i].se, 1'b1, VEC[i].d);
      chk($sformatf("R8 vec%0d mem_wr", i), mem_wr_req, VEC[i].mw);
      chk($sformatf("R8 vec%0d mem_rd", i), mem_rd_req, VEC[i].mr);
      edge_wait();
      chk($sformatf("R3 vec%0d empty", i), empty_ofs, VEC[i].e);
      chk($sformatf("R3 vec%0d full", i), full_ofs, VEC[i].f);
      chk($sformatf("R4 vec%0d rd_data", i), rd_data, VEC[i].rd);
      chk($sformatf("R9 vec%0d rd_valid", i), rd_valid, VEC[i].vld);
    end

    // R1: high defaults, serial method
    do_reset(1'b1, 1'b1);
    chk("R1 empty default hi", empty_ofs, 15'h03FF);
    chk("R1 full default hi", full_ofs, 15'h03FF);

    // R2: serial_sel change after reset has no effect
    serial_sel = 1'b0;

    // R5: first shifted bit (SE[0] = 1) enters full bit 14
    drive(1'b1, 1'b1, 1'b1, 1'b0, SE[0], 18'h0);
    edge_wait();
    chk("R5 first shift full", full_ofs, 15'h41FF);
    chk("R5 first shift empty", empty_ofs, 15'h41FF);
    for (int b = 1; b < 30; b++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b0, (b < 15) ? SE[b] : SF[b-15], 18'h0);
      edge_wait();
    end
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0);
    edge_wait();
    chk("R5 R2 serial empty", empty_ofs, SE);
    chk("R5 R2 serial full", full_ofs, SF);

    // R4: read-back allowed in serial method
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h0);
    edge_wait();
    chk("R4 serial rd empty", rd_data, {3'b000, SE});
    chk("R4 serial rd valid", rd_valid, 1);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h0);
    edge_wait();
    chk("R4 serial rd full", rd_data, {3'b000, SF});

    // R6: parallel write ignored in serial method
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00011);
    edge_wait();
    chk("R6 par wr ignored empty", empty_ofs, SE);
    chk("R6 par wr ignored full", full_ofs, SF);

    // R7: parallel write request blocks the shift
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h00022);
    edge_wait();
    chk("R7 no shift empty", empty_ofs, SE);
    chk("R7 no shift full", full_ofs, SF);

    // R9: no read leaves rd_data and rd_valid idle
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0);
    edge_wait();
    chk("R9 rd_valid idle", rd_valid, 0);
    chk("R9 rd_data held", rd_data, {3'b000, SF});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule